// File: doc/BRIEF.md
# TLB Miss Exception State Capture

This block records the architectural state that a translation-miss interrupt needs. A miss can come from a data access or from an instruction fetch. When the pipeline reports one, the block acts on a single clock edge. It saves the faulting instruction address and the prior machine state. It computes the reduced machine state. For data misses it records the faulting byte address and the syndrome.

On the same edge it prepares a full set of MMU assist fields, so a software refill handler starts with most of a new translation entry already filled in. These fields come from a software-programmed defaults register, the process-ID registers, the victim hint for the set-associative TLB and the missing page number.

In the cycle after the event, the block raises a one-cycle kill. The kill suppresses the faulting instruction. It also tells the machine-state register to take the new value. While the kill is high, a further miss report is ignored, so at most one event is taken every other cycle.

Top module: `tlb_miss_capture`

## Requirements
- R1: A miss is accepted when `miss_valid` is high at a clock edge while `kill` is low. `kill` is high in exactly the following cycle. A miss presented while `kill` is high changes no output register, and `kill` then falls.
- R2: On acceptance, `srr0` takes `fetch_ea` for both miss kinds, and `srr1` takes `msr_cur`.
- R3: On acceptance, `msr_new` takes `msr_cur` with only bits 17, 12 and 9 kept (LSB-0 numbering) and every other bit cleared. `msr_we` is high together with `kill`.
- R4: On a data miss, `dear` takes `data_ea`, with one exception. When the last byte `data_ea + data_last_ofs` lies in a different 4 KiB page and `data_hi_miss` is 1, `dear` takes the first byte address of that second page.
- R5: On a data miss, `esr` takes 32'h0080_0000 (bit 23) when `data_store_cls` is 1, and 0 otherwise.
- R6: On an instruction miss (`miss_is_data` = 0), `dear` and `esr` keep their values.
- R7: `mas_tlbsel`, `mas_tsize`, `mas_attr` and `mas_uattr` take `dflt_tlbsel`, `dflt_tsize`, `dflt_attr` and `dflt_uattr`.
- R8: With `dflt_tlbsel` = 0, `mas_esel` takes `nv_hint` and `mas_nv` takes `~nv_hint`. With `dflt_tlbsel` = 1, both fields are 0.
- R9: After an accepted miss, `mas_valid` = 1, `mas_iprot` = 0, `mas_rpn` = 0 and `mas_perm` = 0.
- R10: `mas_tid` takes `pid0`, `pid1` or `pid2` when `dflt_tidsel` is 0, 1 or 2. The value 3 selects `pid0`.
- R11: `mas_ts` takes `msr_cur` bit 5 for an instruction miss and bit 4 for a data miss.
- R12: `mas_epn` takes bits [31:12] of `fetch_ea` for an instruction miss, and bits [31:12] of the new `dear` value for a data miss.
- R13: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss event report |
| miss_is_data | input | 1 | 1 = data access miss, 0 = instruction fetch miss |
| fetch_ea | input | 32 | Effective address of the faulting instruction |
| data_ea | input | 32 | Effective address of the first accessed byte |
| data_last_ofs | input | 4 | Byte count of the data access minus one |
| data_hi_miss | input | 1 | For a page-crossing access, the second page missed |
| data_store_cls | input | 1 | Access is a store, cache-block invalidate or cache-block zero |
| msr_cur | input | 32 | Current machine state register |
| dflt_tlbsel | input | 1 | Default TLB select |
| dflt_tidsel | input | 2 | Default process-ID select |
| dflt_tsize | input | 4 | Default page size |
| dflt_attr | input | 5 | Default storage attributes |
| dflt_uattr | input | 2 | Default user attributes |
| pid0 | input | 8 | Process-ID register 0 |
| pid1 | input | 8 | Process-ID register 1 |
| pid2 | input | 8 | Process-ID register 2 |
| nv_hint | input | 1 | Next-victim hint for the set-associative TLB |
| kill | output | 1 | Suppress the faulting instruction |
| msr_we | output | 1 | Machine state write strobe |
| msr_new | output | 32 | Machine state value to write |
| srr0 | output | 32 | Saved instruction address |
| srr1 | output | 32 | Saved machine state |
| dear | output | 32 | Data fault address |
| esr | output | 32 | Syndrome |
| mas_tlbsel | output | 1 | Assist: TLB select |
| mas_esel | output | 1 | Assist: entry select |
| mas_nv | output | 1 | Assist: next victim |
| mas_valid | output | 1 | Assist: valid |
| mas_iprot | output | 1 | Assist: invalidation protect |
| mas_tid | output | 8 | Assist: translation ID |
| mas_ts | output | 1 | Assist: address space |
| mas_tsize | output | 4 | Assist: page size |
| mas_epn | output | 20 | Assist: effective page number |
| mas_attr | output | 5 | Assist: storage attributes |
| mas_uattr | output | 2 | Assist: user attributes |
| mas_rpn | output | 20 | Assist: real page number |
| mas_perm | output | 6 | Assist: permissions |

## Verification
The hardest case to reach is a data access whose last byte falls in the next page while that second page is the one reported missing. Random addresses almost never land within a few bytes of a page end. Directed cases therefore place `data_ea` at 0xFFD–0xFFF page offsets, with both values of `data_hi_miss`, and include an access that wraps past the top of the address space. The ignored-event rule is reached by presenting a second, fully randomised miss in every kill cycle and confirming that every register holds its value.

// File: rtl/tlbm_pkg.sv
// Package: shared constants for the TLB miss capture block.
// Assumes a 32-bit machine state register and syndrome, LSB-0 bit numbering.
package tlbm_pkg;
    localparam int MSR_W      = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int MSR_CE     = 17;
    localparam int MSR_ME     = 12;
    localparam int MSR_DE     = 9;
    localparam int MSR_IS     = 5;
    localparam int MSR_DS     = 4;
    localparam int ESR_ST     = 23;
    localparam int PERM_W     = 6;

    localparam logic [MSR_W-1:0] MSR_KEEP =
        (32'd1 << MSR_CE) | (32'd1 << MSR_ME) | (32'd1 << MSR_DE);

    typedef enum logic [1:0] {
        TID_PID0 = 2'd0,
        TID_PID1 = 2'd1,
        TID_PID2 = 2'd2,
        TID_RSVD = 2'd3
    } tid_sel_e;
endpackage

// File: rtl/tlbm_fault_addr.sv
// Module: tlbm_fault_addr
// Computes the data fault address for a miss. It picks the first accessed
// byte, or the first byte of the following page when the access crosses into
// that page and the second page is the one that missed.
// Assumes an access never spans more than two pages (offset < page size).
module tlbm_fault_addr #(
    parameter int ADDR_W  = 32,
    parameter int OFS_W   = 4,
    parameter int PG_SHFT = 12
) (
    input  logic [ADDR_W-1:0] ea,
    input  logic [OFS_W-1:0]  last_ofs,
    input  logic              hi_miss,
    output logic [ADDR_W-1:0] fault_addr
);
    localparam int PN_W = ADDR_W - PG_SHFT;

    logic [ADDR_W-1:0] last_byte;
    logic              crosses;

    // Address of the last accessed byte and the page-crossing test.
    always_comb begin
        last_byte = ea + {{(ADDR_W-OFS_W){1'b0}}, last_ofs};
        crosses   = last_byte[ADDR_W-1:PG_SHFT] != ea[ADDR_W-1:PG_SHFT];
    end

    // Select the reported byte.
    always_comb begin
        if (crosses && hi_miss)
            fault_addr = {last_byte[ADDR_W-1:PG_SHFT], {PG_SHFT{1'b0}}};
        else
            fault_addr = ea;
    end

    logic [PN_W-1:0] unused_pn;
    assign unused_pn = '0;
endmodule

// File: rtl/tlbm_assist_fmt.sv
// Module: tlbm_assist_fmt
// Forms the event-dependent MMU assist fields: the entry select and next
// victim from the victim hint, the translation ID from the selected process
// ID, and the address-space bit from the machine state.
// Assumes the victim hint is already valid in the cycle of the miss.
module tlbm_assist_fmt
    import tlbm_pkg::*;
#(
    parameter int NV_W  = 1,
    parameter int PID_W = 8
) (
    input  logic             is_data,
    input  logic             tlbsel,
    input  logic [1:0]       tidsel,
    input  logic [NV_W-1:0]  nv_hint,
    input  logic [PID_W-1:0] pid0,
    input  logic [PID_W-1:0] pid1,
    input  logic [PID_W-1:0] pid2,
    input  logic [MSR_W-1:0] msr,
    output logic [NV_W-1:0]  esel,
    output logic [NV_W-1:0]  nv,
    output logic [PID_W-1:0] tid,
    output logic             ts
);
    // Victim fields apply only to the set-associative array (select 0).
    always_comb begin
        if (!tlbsel) begin
            esel = nv_hint;
            nv   = ~nv_hint;
        end else begin
            esel = '0;
            nv   = '0;
        end
    end

    // Translation ID from the chosen process-ID register; code 3 maps to PID0.
    always_comb begin
        unique case (tid_sel_e'(tidsel))
            TID_PID1: tid = pid1;
            TID_PID2: tid = pid2;
            default:  tid = pid0;
        endcase
    end

    // Address space follows the instruction or data space bit.
    always_comb ts = is_data ? msr[MSR_DS] : msr[MSR_IS];
endmodule

// File: rtl/tlb_miss_capture.sv
// Module: tlb_miss_capture (top)
// Captures interrupt state and MMU assist fields on a TLB miss in one edge,
// then pulses kill and the machine-state write strobe for one cycle.
// Assumes the pipeline holds no other interrupt in the same cycle. Misses
// reported while kill is high are dropped.
module tlb_miss_capture
    import tlbm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFS_W   = 4,
    parameter int NV_W    = 1,
    parameter int PID_W   = 8,
    parameter int TSIZE_W = 4,
    parameter int ATTR_W  = 5,
    parameter int UATTR_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        miss_valid,
    input  logic                        miss_is_data,
    input  logic [ADDR_W-1:0]           fetch_ea,
    input  logic [ADDR_W-1:0]           data_ea,
    input  logic [OFS_W-1:0]            data_last_ofs,
    input  logic                        data_hi_miss,
    input  logic                        data_store_cls,
    input  logic [MSR_W-1:0]            msr_cur,
    input  logic                        dflt_tlbsel,
    input  logic [1:0]                  dflt_tidsel,
    input  logic [TSIZE_W-1:0]          dflt_tsize,
    input  logic [ATTR_W-1:0]           dflt_attr,
    input  logic [UATTR_W-1:0]          dflt_uattr,
    input  logic [PID_W-1:0]            pid0,
    input  logic [PID_W-1:0]            pid1,
    input  logic [PID_W-1:0]            pid2,
    input  logic [NV_W-1:0]             nv_hint,
    output logic                        kill,
    output logic                        msr_we,
    output logic [MSR_W-1:0]            msr_new,
    output logic [ADDR_W-1:0]           srr0,
    output logic [MSR_W-1:0]            srr1,
    output logic [ADDR_W-1:0]           dear,
    output logic [MSR_W-1:0]            esr,
    output logic                        mas_tlbsel,
    output logic [NV_W-1:0]             mas_esel,
    output logic [NV_W-1:0]             mas_nv,
    output logic                        mas_valid,
    output logic                        mas_iprot,
    output logic [PID_W-1:0]            mas_tid,
    output logic                        mas_ts,
    output logic [TSIZE_W-1:0]          mas_tsize,
    output logic [ADDR_W-PAGE_SHIFT-1:0] mas_epn,
    output logic [ATTR_W-1:0]           mas_attr,
    output logic [UATTR_W-1:0]          mas_uattr,
    output logic [ADDR_W-PAGE_SHIFT-1:0] mas_rpn,
    output logic [PERM_W-1:0]           mas_perm
);
    localparam int EPN_W = ADDR_W - PAGE_SHIFT;

    logic              accept;
    logic [ADDR_W-1:0] fault_addr;
    logic [NV_W-1:0]   esel_d;
    logic [NV_W-1:0]   nv_d;
    logic [PID_W-1:0]  tid_d;
    logic              ts_d;
    logic [EPN_W-1:0]  epn_d;

    // One event at a time: nothing is taken while the kill is pending.
    always_comb accept = miss_valid && !kill;

    tlbm_fault_addr #(
        .ADDR_W  (ADDR_W),
        .OFS_W   (OFS_W),
        .PG_SHFT (PAGE_SHIFT)
    ) u_fault_addr (
        .ea         (data_ea),
        .last_ofs   (data_last_ofs),
        .hi_miss    (data_hi_miss),
        .fault_addr (fault_addr)
    );

    tlbm_assist_fmt #(
        .NV_W  (NV_W),
        .PID_W (PID_W)
    ) u_assist_fmt (
        .is_data (miss_is_data),
        .tlbsel  (dflt_tlbsel),
        .tidsel  (dflt_tidsel),
        .nv_hint (nv_hint),
        .pid0    (pid0),
        .pid1    (pid1),
        .pid2    (pid2),
        .msr     (msr_cur),
        .esel    (esel_d),
        .nv      (nv_d),
        .tid     (tid_d),
        .ts      (ts_d)
    );

    // Page number of the access that missed.
    always_comb epn_d = miss_is_data ? fault_addr[ADDR_W-1:PAGE_SHIFT]
                                     : fetch_ea[ADDR_W-1:PAGE_SHIFT];

    // Kill pulse and machine-state write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) kill <= 1'b0;
        else        kill <= accept;
    end

    always_comb msr_we = kill;

    // Interrupt save state and the reduced machine state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srr0    <= '0;
            srr1    <= '0;
            msr_new <= '0;
        end else if (accept) begin
            srr0    <= fetch_ea;
            srr1    <= msr_cur;
            msr_new <= msr_cur & MSR_KEEP;
        end
    end

    // Data fault address and syndrome, written only by data misses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dear <= '0;
            esr  <= '0;
        end else if (accept && miss_is_data) begin
            dear <= fault_addr;
            esr  <= data_store_cls ? (32'd1 << ESR_ST) : '0;
        end
    end

    // MMU assist fields preloaded for the refill handler.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mas_tlbsel <= 1'b0;
            mas_esel   <= '0;
            mas_nv     <= '0;
            mas_valid  <= 1'b0;
            mas_iprot  <= 1'b0;
            mas_tid    <= '0;
            mas_ts     <= 1'b0;
            mas_tsize  <= '0;
            mas_epn    <= '0;
            mas_attr   <= '0;
            mas_uattr  <= '0;
            mas_rpn    <= '0;
            mas_perm   <= '0;
        end else if (accept) begin
            mas_tlbsel <= dflt_tlbsel;
            mas_esel   <= esel_d;
            mas_nv     <= nv_d;
            mas_valid  <= 1'b1;
            mas_iprot  <= 1'b0;
            mas_tid    <= tid_d;
            mas_ts     <= ts_d;
            mas_tsize  <= dflt_tsize;
            mas_epn    <= epn_d;
            mas_attr   <= dflt_attr;
            mas_uattr  <= dflt_uattr;
            mas_rpn    <= '0;
            mas_perm   <= '0;
        end
    end
endmodule

// File: rtl/tlbm_chk.sv
// Module: tlbm_chk
// Checker for tlb_miss_capture. It watches the top ports only and is bound
// to every instance of the top.
module tlbm_chk
    import tlbm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NV_W   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_is_data,
    input logic [MSR_W-1:0]  msr_cur,
    input logic              dflt_tlbsel,
    input logic              kill,
    input logic              msr_we,
    input logic [MSR_W-1:0]  msr_new,
    input logic [ADDR_W-1:0] srr0,
    input logic [MSR_W-1:0]  srr1,
    input logic [ADDR_W-1:0] dear,
    input logic [MSR_W-1:0]  esr,
    input logic [NV_W-1:0]   mas_esel,
    input logic [NV_W-1:0]   mas_nv,
    input logic              mas_valid,
    input logic              mas_iprot
);
    logic taken;
    assign taken = miss_valid && !kill;

    // R1
    kill_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> kill);
    // R1
    kill_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !kill);
    // R1
    hold_in_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> $stable(srr0) && $stable(srr1) && $stable(dear) && $stable(esr));
    // R2
    srr1_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> srr1 == $past(msr_cur));
    // R3
    msr_reduce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> msr_we && (msr_new == ($past(msr_cur) & MSR_KEEP)));
    // R6
    fetch_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !miss_is_data) |=> $stable(dear) && $stable(esr));
    // R8
    victim_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !dflt_tlbsel) |=> mas_nv == ~mas_esel);
    // R8
    victim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && dflt_tlbsel) |=> (mas_nv == '0) && (mas_esel == '0));
    // R9
    entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> mas_valid && !mas_iprot);
endmodule

bind tlb_miss_capture tlbm_chk #(
    .ADDR_W (ADDR_W),
    .NV_W   (NV_W)
) u_tlbm_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_is_data (miss_is_data),
    .msr_cur      (msr_cur),
    .dflt_tlbsel  (dflt_tlbsel),
    .kill         (kill),
    .msr_we       (msr_we),
    .msr_new      (msr_new),
    .srr0         (srr0),
    .srr1         (srr1),
    .dear         (dear),
    .esr          (esr),
    .mas_esel     (mas_esel),
    .mas_nv       (mas_nv),
    .mas_valid    (mas_valid),
    .mas_iprot    (mas_iprot)
);

// File: tb/tlb_miss_capture_bench.sv
// Bench for tlb_miss_capture: seeded random misses plus directed corner
// cases. Each result is compared with a model built from the requirements.
module tlb_miss_capture_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        miss_valid, miss_is_data, data_hi_miss, data_store_cls;
    logic [31:0] fetch_ea, data_ea, msr_cur;
    logic [3:0]  data_last_ofs, dflt_tsize;
    logic        dflt_tlbsel;
    logic [1:0]  dflt_tidsel, dflt_uattr;
    logic [4:0]  dflt_attr;
    logic [7:0]  pid0, pid1, pid2;
    logic        nv_hint;
    logic        kill, msr_we, mas_tlbsel, mas_valid, mas_iprot, mas_ts;
    logic [31:0] msr_new, srr0, srr1, dear, esr;
    logic        mas_esel, mas_nv;
    logic [7:0]  mas_tid;
    logic [3:0]  mas_tsize;
    logic [19:0] mas_epn, mas_rpn;
    logic [4:0]  mas_attr;
    logic [1:0]  mas_uattr;
    logic [5:0]  mas_perm;

    tlb_miss_capture u_tlb_miss_capture (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid),
        .miss_is_data(miss_is_data), .fetch_ea(fetch_ea), .data_ea(data_ea),
        .data_last_ofs(data_last_ofs), .data_hi_miss(data_hi_miss),
        .data_store_cls(data_store_cls), .msr_cur(msr_cur),
        .dflt_tlbsel(dflt_tlbsel), .dflt_tidsel(dflt_tidsel),
        .dflt_tsize(dflt_tsize), .dflt_attr(dflt_attr), .dflt_uattr(dflt_uattr),
        .pid0(pid0), .pid1(pid1), .pid2(pid2), .nv_hint(nv_hint),
        .kill(kill), .msr_we(msr_we), .msr_new(msr_new), .srr0(srr0),
        .srr1(srr1), .dear(dear), .esr(esr), .mas_tlbsel(mas_tlbsel),
        .mas_esel(mas_esel), .mas_nv(mas_nv), .mas_valid(mas_valid),
        .mas_iprot(mas_iprot), .mas_tid(mas_tid), .mas_ts(mas_ts),
        .mas_tsize(mas_tsize), .mas_epn(mas_epn), .mas_attr(mas_attr),
        .mas_uattr(mas_uattr), .mas_rpn(mas_rpn), .mas_perm(mas_perm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Expected register model.
    logic [31:0] x_srr0, x_srr1, x_msr, x_dear, x_esr;
    logic        x_tlbsel, x_esel, x_nv, x_valid, x_ts;
    logic [7:0]  x_tid;
    logic [3:0]  x_tsize;
    logic [19:0] x_epn;
    logic [4:0]  x_attr;
    logic [1:0]  x_uattr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_dear(input logic [31:0] ea, input logic [3:0] ofs,
                                           input logic hi);
        logic [31:0] lastb;
        lastb = ea + {28'd0, ofs};
        if ((lastb >> 12) != (ea >> 12) && hi) return lastb & 32'hFFFF_F000;
        return ea;
    endfunction

    function automatic logic [7:0] f_tid(input logic [1:0] s);
        if (s == 2'd1) return pid1;
        if (s == 2'd2) return pid2;
        return pid0;
    endfunction

    task automatic model_reset();
        x_srr0 = 0; x_srr1 = 0; x_msr = 0; x_dear = 0; x_esr = 0;
        x_tlbsel = 0; x_esel = 0; x_nv = 0; x_valid = 0; x_ts = 0;
        x_tid = 0; x_tsize = 0; x_epn = 0; x_attr = 0; x_uattr = 0;
    endtask

    task automatic model_accept();
        x_srr0 = fetch_ea;
        x_srr1 = msr_cur;
        x_msr  = msr_cur & 32'h0002_1200;
        if (miss_is_data) begin
            x_dear = f_dear(data_ea, data_last_ofs, data_hi_miss);
            x_esr  = data_store_cls ? 32'h0080_0000 : 32'h0;
            x_epn  = x_dear[31:12];
            x_ts   = msr_cur[4];
        end else begin
            x_epn = fetch_ea[31:12];
            x_ts  = msr_cur[5];
        end
        x_tlbsel = dflt_tlbsel;
        x_esel   = dflt_tlbsel ? 1'b0 : nv_hint;
        x_nv     = dflt_tlbsel ? 1'b0 : ~nv_hint;
        x_valid  = 1'b1;
        x_tid    = f_tid(dflt_tidsel);
        x_tsize  = dflt_tsize;
        x_attr   = dflt_attr;
        x_uattr  = dflt_uattr;
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " R2 srr0"}, srr0, x_srr0);
        chk({tag, " R2 srr1"}, srr1, x_srr1);
        chk({tag, " R3 msr_new"}, msr_new, x_msr);
        chk({tag, " R4 R6 dear"}, dear, x_dear);
        chk({tag, " R5 R6 esr"}, esr, x_esr);
        chk({tag, " R7 tlbsel"}, 32'(mas_tlbsel), 32'(x_tlbsel));
        chk({tag, " R7 tsize/attr/uattr"}, {21'd0, mas_tsize, mas_attr, mas_uattr},
            {21'd0, x_tsize, x_attr, x_uattr});
        chk({tag, " R8 esel/nv"}, {30'd0, mas_esel, mas_nv}, {30'd0, x_esel, x_nv});
        chk({tag, " R9 valid/iprot"}, {30'd0, mas_valid, mas_iprot}, {30'd0, x_valid, 1'b0});
        chk({tag, " R9 rpn/perm"}, {6'd0, mas_rpn, mas_perm}, 32'd0);
        chk({tag, " R10 tid"}, 32'(mas_tid), 32'(x_tid));
        chk({tag, " R11 ts"}, 32'(mas_ts), 32'(x_ts));
        chk({tag, " R12 epn"}, 32'(mas_epn), 32'(x_epn));
    endtask

    task automatic rand_inputs();
        miss_is_data   = 1'($urandom);
        fetch_ea       = $urandom;
        data_ea        = $urandom;
        data_last_ofs  = 4'($urandom);
        data_hi_miss   = 1'($urandom);
        data_store_cls = 1'($urandom);
        msr_cur        = $urandom;
        dflt_tlbsel    = 1'($urandom);
        dflt_tidsel    = 2'($urandom);
        dflt_tsize     = 4'($urandom);
        dflt_attr      = 5'($urandom);
        dflt_uattr     = 2'($urandom);
        pid0           = 8'($urandom);
        pid1           = 8'($urandom);
        pid2           = 8'($urandom);
        nv_hint        = 1'($urandom);
    endtask

    // Present one miss (caller is at a falling edge), check the result, then
    // present an ignored miss during the kill cycle and check that nothing moved.
    task automatic fire(input string tag);
        miss_valid = 1'b1;
        model_accept();
        @(posedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        chk({tag, " R1 kill high"}, 32'(kill), 32'd1);
        chk({tag, " R3 msr_we"}, 32'(msr_we), 32'd1);
        check_regs(tag);
        rand_inputs();
        miss_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        chk({tag, " R1 kill falls"}, 32'(kill), 32'd0);
        check_regs({tag, " R1 ignored"});
    endtask

    initial begin
        void'($urandom(32'h1D5E_ED01));
        rst_n = 1'b0;
        miss_valid = 1'b0;
        rand_inputs();
        model_reset();
        repeat (3) @(negedge clk);
        chk("R13 kill", 32'(kill), 32'd0);
        check_regs("R13 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R4 crossing, second page missing.
        rand_inputs(); miss_is_data = 1; data_ea = 32'h1234_5FFD;
        data_last_ofs = 4'd7; data_hi_miss = 1; fire("R4 cross-hi");
        chk("R4 cross-hi value", dear, 32'h1234_6000);
        // R4 crossing, first page missing.
        rand_inputs(); miss_is_data = 1; data_ea = 32'h1234_5FFD;
        data_last_ofs = 4'd7; data_hi_miss = 0; fire("R4 cross-lo");
        // R4 wrap past the top of the address space.
        rand_inputs(); miss_is_data = 1; data_ea = 32'hFFFF_FFFF;
        data_last_ofs = 4'd1; data_hi_miss = 1; fire("R4 wrap");
        // R4 no crossing, last byte at page end.
        rand_inputs(); miss_is_data = 1; data_ea = 32'hABCD_EFF0;
        data_last_ofs = 4'd15; data_hi_miss = 1; fire("R4 edge");
        // R5 store-class.
        rand_inputs(); miss_is_data = 1; data_store_cls = 1; fire("R5 store");
        // R6 fetch miss after data miss.
        rand_inputs(); miss_is_data = 0; fire("R6 fetch");
        // R10 select 3 maps to pid0, and select 2.
        rand_inputs(); dflt_tidsel = 2'd3; fire("R10 sel3");
        rand_inputs(); dflt_tidsel = 2'd2; fire("R10 sel2");
        // R8 both TLB selects.
        rand_inputs(); dflt_tlbsel = 1; nv_hint = 1; fire("R8 tlb1");
        rand_inputs(); dflt_tlbsel = 0; nv_hint = 1; fire("R8 tlb0");

        for (int i = 0; i < 300; i++) begin
            rand_inputs();
            if (i % 4 == 0) data_ea[11:0] = 12'hFF0 | 12'($urandom % 16);
            fire("rand");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule